// File: doc/BRIEF.md
# SDR SDRAM Power-Up Command Sequencer

This block drives the command, address and control pins of a single-data-rate SDRAM from reset until the memory is ready for ordinary traffic. Straight out of reset it keeps clock enable and every data-mask line high and places a no-operation command on the bus. It holds that for a long settle period. It then closes all banks with one precharge-all command, runs a programmable number of auto-refresh commands, and finally loads the mode register with a word assembled from parameters. Once the mode-load recovery time has passed, it raises a ready flag and leaves the bus idle so that the memory controller can take over.

Every interval is a parameter counted in clock cycles. The defaults suit a 133 MHz clock: a 200 µs settle period, a 3-cycle precharge time, a 10-cycle refresh cycle time and a 2-cycle mode-load recovery. Reset is synchronous and active low. A reset at any point restarts the whole sequence. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `sdr_pwrup_seq`

## Requirements
- R1: While `rst_n` is low and for the first `T_WAIT` cycles after it rises, the bus carries NOP (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1) with `sd_addr`=0, `sd_ba`=0, every `sd_dqm` bit 1 and `init_done`=0.
- R2: In cycle `T_WAIT` after reset release (cycles counted from 0), a precharge-all is driven: `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, `sd_addr[10]`=1, all other address bits 0, `sd_ba`=0.
- R3: The first auto-refresh (`sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=1, address and bank 0) appears exactly `T_RP` cycles after the precharge-all.
- R4: Exactly `N_REF` auto-refresh commands are issued, each one `T_RFC` cycles after the one before it.
- R5: The mode-register load (all four command pins 0) appears exactly `T_RFC` cycles after the last refresh and is issued only once.
- R6: During the mode load, `sd_addr[2:0]` carries `MODE_BL`, `sd_addr[3]` carries `MODE_BT`, `sd_addr[6:4]` carries `MODE_CL`, and `sd_addr[9]` carries `MODE_WM`. `sd_addr[8:7]`, `sd_addr[10]`, all higher address bits and `sd_ba` are 0.
- R7: Every cycle between the commands of R2 to R5 carries NOP with address 0 and bank 0.
- R8: `init_done` rises exactly `T_MRD` cycles after the mode load and stays high until reset. While it is high the bus carries NOP and `sd_dqm` is all zeros.
- R9: Asserting `rst_n` low at any point, including mid-sequence or after ready, returns the bus to the R1 state and clears `init_done` from the next clock edge. On release the sequence repeats from the settle period with R2 timing.
- R10: `sd_cke` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | DQM_W | Data masks; high until ready, then low |
| sd_ba | output | BA_W | Bank address, always 0 here |
| sd_addr | output | ADDR_W | Address lines; A10 selects all banks, mode word during load |
| init_done | output | 1 | High once the memory is initialised |

## Verification
The sequencer has no data input, so the stimulus patterns are reset timings. The first pattern is one clean release, compared cycle by cycle against an event table. This separates a command that comes a cycle early or late, or is the wrong type, from correct timing. The second pattern asserts reset in the middle of the refresh train, and the third asserts it after ready has risen. Each is followed by a second full pass. These patterns show whether the counters, the refresh tally and the ready flag are truly restarted, or are left holding stale state. The bench sets the mode parameters to non-zero values with distinct bits, so that a field placed on the wrong address line shows up as a wrong mode word.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_AREF = 2'd2,
    CMD_LMR  = 2'd3
  } init_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t pins_of(init_cmd_e c);
    cmd_pins_t p;
    case (c)
      CMD_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_AREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_LMR:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/init_dcnt.sv
module init_dcnt #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= W'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import sdr_init_pkg::*;
#(
  parameter int T_WAIT = 26600,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2,
  parameter int N_REF  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  output init_cmd_e cmd,
  output logic      ready
);
  localparam int TMAX1 = (T_WAIT > T_RFC) ? T_WAIT : T_RFC;
  localparam int TMAX2 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int RW    = $clog2(N_REF + 1);

  typedef enum logic [2:0] {
    S_WAIT, S_PALL, S_TRP, S_AREF, S_TRFC, S_LMR, S_TMRD, S_DONE
  } st_e;

  st_e          st, st_nx;
  logic         load;
  logic [CW-1:0] load_val;
  logic         cnt_zero;
  logic [RW-1:0] ref_cnt;
  logic         ref_last;

  init_dcnt #(.W(CW), .RST_VAL(T_WAIT - 1)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (cnt_zero)
  );

  assign ref_last = (ref_cnt == RW'(N_REF));

  always_comb begin
    st_nx    = st;
    load     = 1'b0;
    load_val = '0;
    case (st)
      S_WAIT: if (cnt_zero) st_nx = S_PALL;
      S_PALL: begin
        load = 1'b1; load_val = CW'(T_RP - 2); st_nx = S_TRP;
      end
      S_TRP:  if (cnt_zero) st_nx = S_AREF;
      S_AREF: begin
        load = 1'b1; load_val = CW'(T_RFC - 2); st_nx = S_TRFC;
      end
      S_TRFC: if (cnt_zero) st_nx = ref_last ? S_LMR : S_AREF;
      S_LMR: begin
        load = 1'b1; load_val = CW'(T_MRD - 2); st_nx = S_TMRD;
      end
      S_TMRD: if (cnt_zero) st_nx = S_DONE;
      default: st_nx = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      ref_cnt <= '0;
    end else begin
      st <= st_nx;
      if (st == S_AREF) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  always_comb begin
    case (st)
      S_PALL:  cmd = CMD_PALL;
      S_AREF:  cmd = CMD_AREF;
      S_LMR:   cmd = CMD_LMR;
      default: cmd = CMD_NOP;
    endcase
  end

  assign ready = (st == S_DONE);
endmodule

// File: rtl/init_cmd_drv.sv
module init_cmd_drv
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 8
) (
  input  init_cmd_e         cmd,
  input  logic              ready,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  localparam int ALL_BANK_BIT = 10;
  cmd_pins_t p;

  always_comb begin
    p = pins_of(cmd);
    cs_n  = p.cs_n;
    ras_n = p.ras_n;
    cas_n = p.cas_n;
    we_n  = p.we_n;
    cke   = 1'b1;
    dqm   = ready ? '0 : '1;
    ba    = '0;
    addr  = '0;
    if (cmd == CMD_PALL) addr[ALL_BANK_BIT] = 1'b1;
    if (cmd == CMD_LMR)  addr = mode_word;
  end
endmodule

// File: rtl/sdr_pwrup_seq.sv
module sdr_pwrup_seq
  import sdr_init_pkg::*;
#(
  parameter int         T_WAIT  = 26600,
  parameter int         T_RP    = 3,
  parameter int         T_RFC   = 10,
  parameter int         T_MRD   = 2,
  parameter int         N_REF   = 8,
  parameter int         ADDR_W  = 12,
  parameter int         BA_W    = 2,
  parameter int         DQM_W   = 8,
  parameter logic [2:0] MODE_BL = 3'b011,
  parameter logic       MODE_BT = 1'b0,
  parameter logic [2:0] MODE_CL = 3'b011,
  parameter logic       MODE_WM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam logic [9:0] MODE_LO = {MODE_WM, 2'b00, MODE_CL, MODE_BT, MODE_BL};
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_LO);

  init_cmd_e cmd;
  logic      ready;

  init_fsm #(
    .T_WAIT (T_WAIT), .T_RP (T_RP), .T_RFC (T_RFC),
    .T_MRD  (T_MRD),  .N_REF (N_REF)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .ready (ready)
  );

  init_cmd_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)) u_drv (
    .cmd       (cmd),
    .ready     (ready),
    .mode_word (MODE_WORD),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .cke       (sd_cke),
    .dqm       (sd_dqm),
    .ba        (sd_ba),
    .addr      (sd_addr)
  );

  assign init_done = ready;
endmodule

// File: rtl/sdr_pwrup_seq_chk.sv
module sdr_pwrup_seq_chk #(
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2,
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  logic is_pall, is_ref, is_lmr, is_nop;
  logic [15:0] since_ref, since_lmr;

  assign is_pall = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;
  assign is_ref  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;
  assign is_lmr  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000;
  assign is_nop  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= '0;
      since_lmr <= '0;
    end else begin
      if (is_ref)                  since_ref <= 16'd1;
      else if (since_ref != '0 && since_ref != '1) since_ref <= since_ref + 1'b1;
      if (is_lmr)                  since_lmr <= 16'd1;
      else if (since_lmr != '0 && since_lmr != '1) since_lmr <= since_lmr + 1'b1;
    end
  end

  p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);
  p_pall_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> sd_addr[10] && sd_ba == '0);
  p_mode_zero_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> sd_ba == '0 && sd_addr[8:7] == 2'b00 && !sd_addr[10]);
  p_ref_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref && since_ref != '0 |-> since_ref == 16'(T_RFC));
  p_lmr_after_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> since_ref == 16'(T_RFC));
  p_ready_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> since_lmr == 16'(T_MRD));
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_idle_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop && sd_dqm == '0);
  p_masked_before_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> sd_dqm == '1);
endmodule

bind sdr_pwrup_seq sdr_pwrup_seq_chk #(
  .T_RFC (T_RFC), .T_MRD (T_MRD), .ADDR_W (ADDR_W), .BA_W (BA_W), .DQM_W (DQM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sdr_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdr_pwrup_seq_tb;
  localparam int W = 20, RP = 3, RFC = 4, MRD = 2, NR = 8;
  localparam int AW = 12, BW = 2, DW = 8;
  localparam int NEV = NR + 3;
  localparam int T_LMR = W + RP + (NR - 1) * RFC + RFC;
  localparam int T_RDY = T_LMR + MRD;
  localparam int LAST  = T_RDY + 6;
  localparam logic [AW-1:0] EXP_MODE = AW'((1 << 9) | (3 << 4) | (1 << 3) | 3);

  // event table: cycle offset after release, kind (1 PALL, 2 AREF, 3 LMR, 4 READY)
  localparam int EV_T [NEV] = '{W, W+RP, W+RP+RFC, W+RP+2*RFC, W+RP+3*RFC,
    W+RP+4*RFC, W+RP+5*RFC, W+RP+6*RFC, W+RP+7*RFC, T_LMR, T_RDY};
  localparam int EV_K [NEV] = '{1, 2, 2, 2, 2, 2, 2, 2, 2, 3, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, done;
  logic [DW-1:0] dqm;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdr_pwrup_seq #(
    .T_WAIT(W), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD), .N_REF(NR),
    .ADDR_W(AW), .BA_W(BW), .DQM_W(DW),
    .MODE_BL(3'b011), .MODE_BT(1'b1), .MODE_CL(3'b011), .MODE_WM(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_cke(cke), .sd_dqm(dqm),
    .sd_ba(ba), .sd_addr(addr), .init_done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // compare the bus with the expected command for one cycle
  task automatic expect_cycle(input int k, input string tag_nop);
    int kind = 0;
    logic [3:0] ep;
    logic [AW-1:0] ea;
    string req;
    for (int i = 0; i < NEV; i++) if (EV_T[i] == k) kind = EV_K[i];
    if (k >= T_RDY) kind = 4;
    ep = 4'b0111; ea = '0; req = tag_nop;
    case (kind)
      1: begin ep = 4'b0010; ea = AW'(1 << 10); req = "R2"; end
      2: begin ep = 4'b0001; req = (k == W + RP) ? "R3" : "R4"; end
      3: begin ep = 4'b0000; ea = EXP_MODE; req = "R5"; end
      4: req = "R8";
      default: ;
    endcase
    check({cs_n, ras_n, cas_n, we_n} == ep, req, "command pins", 32'({cs_n, ras_n, cas_n, we_n}), 32'(ep));
    check(addr == ea && ba == '0, (kind == 3) ? "R6" : req, "addr/bank", 32'({ba, addr}), 32'(ea));
    check(done == (k >= T_RDY), "R8", "init_done", 32'(done), 32'(k >= T_RDY));
    check(dqm == ((k >= T_RDY) ? '0 : '1), (k >= T_RDY) ? "R8" : "R1", "dqm", 32'(dqm), 32'((k >= T_RDY) ? 8'h00 : 8'hff));
    check(cke === 1'b1, "R10", "cke", 32'(cke), 32'd1);
  endtask

  task automatic check_reset_state(input string req);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, "NOP in reset", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
    check(done == 1'b0 && dqm == '1, req, "ready/dqm in reset", 32'({done, dqm}), 32'h0ff);
    check(addr == '0 && ba == '0 && cke, req, "addr/bank/cke in reset", 32'({cke, ba, addr}), 32'h4000);
  endtask

  // release at a negedge, then check cycles 0..upto against the table
  task automatic run_from_release(input int upto, input string tag_nop);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k <= upto; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      expect_cycle(k, (k < W) ? "R1" : tag_nop);
    end
  endtask

  task automatic apply_reset(input string req);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check_reset_state(req);
    repeat (2) @(posedge clk);
    #1 check_reset_state(req);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_reset_state("R1");
    @(negedge clk);
    // pass 1: full clean sequence
    run_from_release(LAST, "R7");
    // pass 2: reset in the middle of the refresh train, then full sequence
    apply_reset("R9");
    run_from_release(W + RP + 3 * RFC + 1, "R9");
    apply_reset("R9");
    run_from_release(LAST, "R9");
    // pass 3: reset after ready, ready must clear, then full sequence
    apply_reset("R9");
    run_from_release(LAST, "R9");
    // single mode load per pass: ready held and bus idle for many cycles
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && done, "R5", "no repeat after ready",
            32'({done, cs_n, ras_n, cas_n, we_n}), 32'h17);
    end
    finish_run();
  end
endmodule